// File: doc/BRIEF.md
# Extended-Capability Parallel Port Host Register Front End

This block is the host-facing register file of an extended-capability parallel port. The host issues single-cycle reads and writes at an offset from the port's base address. The block decodes each access against the operating mode held in an extended control register, so one offset can mean a different register in each mode. An address-enable input can veto any cycle.

Writes go to one of four places:
- the eight-bit output latch that drives the port data lines;
- the control register;
- the configuration registers;
- a 16-entry transmit queue.

Each queue entry is nine bits wide. The top bit marks the byte as a command byte (address or run-length count) or as a plain data byte.

A downstream transmitter, outside this block, drains the queue through a valid/ready pair. The queue head and its tag are offered to the transmitter only in the two forward queue modes. In test mode the host reads the queue back instead. Read data is registered and appears on `bus_rdata` one clock after the read strobe. It then holds until the next accepted read.

Top module: `ecp_host_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the following at that edge: the output latch (`pd_out` = 00h), the control register, configuration register B and the mode (000). It also empties the queue, so a read of the extended control register afterwards returns 01h.
- R2: In mode 000 or 001, a write at offset 000h appears unchanged on `pd_out` after the next edge. A read at 000h returns the live `pd_in` value, not the latched byte.
- R3: While `bus_aen` is high, a write changes no state and a read leaves `bus_rdata` unchanged.
- R4: In every mode, offset 001h reads `stat_in`, offset 002h is a read/write control register, and offset 402h is the extended control register.
- R5: The extended control register holds the mode in bits 7:5, queue-full in bit 1 and queue-empty in bit 0, with bits 4:2 reading 0. A write changes only the mode field.
- R6: In mode 011, a write at 000h enqueues the byte with tag 1 (command), but only while control bit 5 (direction) is 0. With that bit at 1, the write is ignored.
- R7: In modes 010, 011 and 110, a write at offset 400h enqueues the byte with tag 0 (data).
- R8: `tx_valid` is high exactly when the queue is not empty and the mode is 010 or 011. Entries leave in write order, one per cycle with `tx_valid` and `tx_ready` both high. `tx_tag` gives each entry's tag.
- R9: In mode 110, a read at 400h returns the oldest entry and removes it. If the queue is empty the read returns 00h. `tx_valid` stays low in this mode.
- R10: Only in mode 111, offset 400h reads the fixed value `CFGA_VALUE` (default 10h), which writes cannot change, and offset 401h is the read/write configuration register B. In other modes 401h reads 00h and ignores writes.
- R11: A write selecting mode 100 takes effect only when bit 0 of configuration register B is 1. Otherwise the mode stays as it was.
- R12: The queue holds 16 entries. A write while the queue is full is dropped.
- R13: A write that changes the mode empties the queue. A change from one of the modes 010, 011 and 110 to another of the three keeps the queue contents.
- R14: An access at an offset that is undefined in the current mode reads 00h and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_aen | input | 1 | Address enable. When high, the cycle is ignored. |
| bus_addr | input | 11 | Offset from the port base address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pd_in | input | 8 | Sampled state of the port data lines |
| pd_out | output | 8 | Output latch driving the port data lines |
| stat_in | input | 8 | Peripheral status lines |
| tx_valid | output | 1 | Queue head offered to the transmitter |
| tx_tag | output | 1 | Head tag: 1 = command byte, 0 = data byte |
| tx_data | output | 8 | Head byte |
| tx_ready | input | 1 | Transmitter accepts the head |

## Verification
The bench targets the mode-dependent corners:
- Command writes made with the direction bit set must leave no entry. A design that skipped the direction check would send a stray command byte.
- The seventeenth write into a full queue must vanish. A wrap-around bug would show up as a lost or repeated byte.
- A move between the queue modes must keep the entries, while a move to any other mode must empty the queue. A design that got either wrong would leave the empty flag wrong.
- A request for mode 100 must be refused until the configuration enable bit is set.
- Offset 000h must read back the pins rather than the latch.
- Test-mode reads of an empty queue must return 00h.
- Undefined offsets must return 00h and change nothing.

// File: rtl/ecp_regs_pkg.sv
// Package: shared constants, types and helpers for the parallel port
// host register front end.
// Assumes an 11-bit offset window above the port base address.
package ecp_regs_pkg;

    localparam int ADDR_W = 11;
    localparam int BYTE_W = 8;
    localparam int ENTRY_W = BYTE_W + 1;

    // Operating mode codes held in the extended control register
    typedef enum logic [2:0] {
        MD_SPP   = 3'b000,
        MD_BIDIR = 3'b001,
        MD_PFIFO = 3'b010,
        MD_ECP   = 3'b011,
        MD_EPP   = 3'b100,
        MD_RSVD  = 3'b101,
        MD_TEST  = 3'b110,
        MD_CFG   = 3'b111
    } port_mode_e;

    // Register offsets from the base address
    localparam logic [ADDR_W-1:0] OFS_DATA = 11'h000;
    localparam logic [ADDR_W-1:0] OFS_STAT = 11'h001;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 11'h002;
    localparam logic [ADDR_W-1:0] OFS_FIFO = 11'h400;
    localparam logic [ADDR_W-1:0] OFS_CFGB = 11'h401;
    localparam logic [ADDR_W-1:0] OFS_XCTL = 11'h402;

    // Field positions
    localparam int CTRL_DIR_BIT  = 5;
    localparam int XCTL_MODE_LO  = 5;
    localparam int XCTL_MODE_HI  = 7;
    localparam int CFGB_EPP_BIT  = 0;

    // Queue entry tag values
    localparam logic TAG_CMD  = 1'b1;
    localparam logic TAG_DATA = 1'b0;

    // Source of the read data for one access
    typedef enum logic [2:0] {
        RS_NONE,
        RS_PINS,
        RS_STAT,
        RS_CTRL,
        RS_XCTL,
        RS_CFGA,
        RS_CFGB,
        RS_FIFO
    } rd_src_e;

    // Decoded strobes for one bus cycle
    typedef struct packed {
        logic    wr_latch;
        logic    push_cmd;
        logic    push_data;
        logic    wr_ctrl;
        logic    wr_xctl;
        logic    wr_cfgb;
        logic    pop;
        rd_src_e rd_src;
    } acc_dec_t;

    // True for modes that share the queue without flushing it
    function automatic logic in_queue_group(input port_mode_e m);
        return (m == MD_PFIFO) || (m == MD_ECP) || (m == MD_TEST);
    endfunction

endpackage

// File: rtl/ecp_access_decode.sv
// Module: turns one host bus cycle into register strobes and a read source,
// based on the current mode.
// Assumes single-cycle strobes. An address-enable high vetoes the whole cycle.
module ecp_access_decode
    import ecp_regs_pkg::*;
(
    input  port_mode_e         mode,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    input  logic               rd,
    input  logic               aen,
    input  logic               dir,
    input  logic               q_empty,
    output acc_dec_t           dec
);

    logic go_wr;
    logic go_rd;

    // Qualify the strobes with the address enable
    always_comb begin
        go_wr = wr && !aen;
        go_rd = rd && !aen;
    end

    // Offset and mode decode
    always_comb begin
        dec        = '0;
        dec.rd_src = RS_NONE;
        case (addr)
            OFS_DATA: begin
                if (mode == MD_SPP || mode == MD_BIDIR) begin
                    dec.wr_latch = go_wr;
                    if (go_rd) dec.rd_src = RS_PINS;
                end else if (mode == MD_ECP) begin
                    dec.push_cmd = go_wr && !dir;
                end
            end
            OFS_STAT: begin
                if (go_rd) dec.rd_src = RS_STAT;
            end
            OFS_CTRL: begin
                dec.wr_ctrl = go_wr;
                if (go_rd) dec.rd_src = RS_CTRL;
            end
            OFS_XCTL: begin
                dec.wr_xctl = go_wr;
                if (go_rd) dec.rd_src = RS_XCTL;
            end
            OFS_FIFO: begin
                case (mode)
                    MD_PFIFO, MD_ECP: begin
                        dec.push_data = go_wr;
                    end
                    MD_TEST: begin
                        dec.push_data = go_wr;
                        if (go_rd && !q_empty) begin
                            dec.rd_src = RS_FIFO;
                            dec.pop    = 1'b1;
                        end
                    end
                    MD_CFG: begin
                        if (go_rd) dec.rd_src = RS_CFGA;
                    end
                    default: ;
                endcase
            end
            OFS_CFGB: begin
                if (mode == MD_CFG) begin
                    dec.wr_cfgb = go_wr;
                    if (go_rd) dec.rd_src = RS_CFGB;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ecp_tag_fifo.sv
// Module: synchronous queue of tagged entries with push, pop and flush.
// Assumes a pop is only requested while the queue is not empty.
// A push while full is dropped, even if a pop happens in the same cycle.
// Flush has priority over push and pop.
module ecp_tag_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CW-1:0]    count;
    logic             push_ok, pop_ok;

    // Pointer advance: natural wrap for power-of-two depths, compare otherwise
    generate
        if (DEPTH == (1 << PW)) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Qualify requests with the occupancy flags
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        head    = mem[rd_ptr];
    end

    // Entry storage
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Pointers and occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_nxt;
            if (pop_ok)  rd_ptr <= rd_nxt;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/ecp_xctl_reg.sv
// Module: holds the mode field of the extended control register.
// Gates mode 100 behind the configuration enable bit and requests a queue
// flush on mode changes that leave the queue-sharing group.
// Assumes the flush request is used in the same cycle as the write.
module ecp_xctl_reg
    import ecp_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              epp_allow,
    output port_mode_e        mode,
    output logic              flush
);

    port_mode_e req_mode;
    logic       accept;

    // Decide whether the requested mode is taken and whether it flushes
    always_comb begin
        req_mode = port_mode_e'(wdata[XCTL_MODE_HI:XCTL_MODE_LO]);
        accept   = wr_en && (req_mode != mode)
                   && ((req_mode != MD_EPP) || epp_allow);
        flush    = accept && !(in_queue_group(mode) && in_queue_group(req_mode));
    end

    // Mode register
    always_ff @(posedge clk) begin
        if (!rst_n)      mode <= MD_SPP;
        else if (accept) mode <= req_mode;
    end

endmodule

// File: rtl/ecp_host_regs.sv
// Module: top of the parallel port host register front end.
// Decodes host cycles, keeps the data latch, control and configuration
// registers, and feeds the tagged transmit queue to a valid/ready consumer.
// Assumes single-cycle read/write strobes. Read data is registered.
module ecp_host_regs
    import ecp_regs_pkg::*;
#(
    parameter int                FIFO_DEPTH = 16,
    parameter logic [BYTE_W-1:0] CFGA_VALUE = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_aen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [BYTE_W-1:0] pd_in,
    output logic [BYTE_W-1:0] pd_out,
    input  logic [BYTE_W-1:0] stat_in,
    output logic              tx_valid,
    output logic              tx_tag,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready
);

    acc_dec_t           dec;
    port_mode_e         cur_mode;
    logic               fifo_flush, fifo_full, fifo_empty;
    logic               fifo_push, fifo_pop, tx_take;
    logic [ENTRY_W-1:0] fifo_din, fifo_head;
    logic [BYTE_W-1:0]  ctrl_q, cfgb_q, rd_val;

    ecp_access_decode u_dec (
        .mode    (cur_mode),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .aen     (bus_aen),
        .dir     (ctrl_q[CTRL_DIR_BIT]),
        .q_empty (fifo_empty),
        .dec     (dec)
    );

    ecp_xctl_reg u_xctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (dec.wr_xctl),
        .wdata     (bus_wdata),
        .epp_allow (cfgb_q[CFGB_EPP_BIT]),
        .mode      (cur_mode),
        .flush     (fifo_flush)
    );

    ecp_tag_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (ENTRY_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (fifo_din),
        .pop   (fifo_pop),
        .flush (fifo_flush),
        .head  (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // Queue feed and transmitter handshake
    always_comb begin
        fifo_push = dec.push_cmd || dec.push_data;
        fifo_din  = {dec.push_cmd ? TAG_CMD : TAG_DATA, bus_wdata};
        tx_valid  = !fifo_empty && (cur_mode == MD_PFIFO || cur_mode == MD_ECP);
        tx_take   = tx_valid && tx_ready;
        fifo_pop  = dec.pop || tx_take;
        tx_data   = fifo_head[BYTE_W-1:0];
        tx_tag    = fifo_head[ENTRY_W-1];
    end

    // Output data latch
    always_ff @(posedge clk) begin
        if (!rst_n)            pd_out <= '0;
        else if (dec.wr_latch) pd_out <= bus_wdata;
    end

    // Control and configuration B registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cfgb_q <= '0;
        end else begin
            if (dec.wr_ctrl) ctrl_q <= bus_wdata;
            if (dec.wr_cfgb) cfgb_q <= bus_wdata;
        end
    end

    // Read data selection
    always_comb begin
        case (dec.rd_src)
            RS_PINS: rd_val = pd_in;
            RS_STAT: rd_val = stat_in;
            RS_CTRL: rd_val = ctrl_q;
            RS_XCTL: rd_val = {cur_mode, 3'b000, fifo_full, fifo_empty};
            RS_CFGA: rd_val = CFGA_VALUE;
            RS_CFGB: rd_val = cfgb_q;
            RS_FIFO: rd_val = fifo_head[BYTE_W-1:0];
            default: rd_val = '0;
        endcase
    end

    // Registered read data, updated only on accepted reads
    always_ff @(posedge clk) begin
        if (!rst_n)                   bus_rdata <= '0;
        else if (bus_rd && !bus_aen)  bus_rdata <= rd_val;
    end

endmodule

// File: rtl/ecp_host_regs_chk.sv
// Module: assertion checker for the parallel port host register front end.
// Attached to the top module by the bind below. Observes ports and the
// signals that connect the submodules.
module ecp_host_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_aen,
    input logic        bus_wr,
    input logic [10:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  pd_out,
    input logic [2:0]  mode,
    input logic        fifo_full,
    input logic        fifo_empty,
    input logic        fifo_flush,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_tag,
    input logic [7:0]  tx_data
);

    // R1: reset clears the output latch
    a_r1_reset_clears_latch: assert property (@(posedge clk)
        !rst_n |=> pd_out == 8'h00);

    // R3: vetoed cycles leave the latch alone
    a_r3_aen_blocks_latch: assert property (@(posedge clk) disable iff (!rst_n)
        bus_aen |=> $stable(pd_out));

    // R2: a data write in modes 000/001 lands on the pins unchanged
    a_r2_latch_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_aen && bus_addr == 11'h000 && mode <= 3'b001)
        |=> pd_out == $past(bus_wdata));

    // R12: full and empty never together
    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R13: a flush leaves the queue empty
    a_r13_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> fifo_empty);

    // R8: transmitter sees entries only in the forward queue modes
    a_r8_tx_forward_modes: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (mode == 3'b010 || mode == 3'b011));

    // R8: an offered entry is held until taken, unless the mode is rewritten
    a_r8_tx_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !(bus_wr && !bus_aen && bus_addr == 11'h402))
        |=> tx_valid && $stable(tx_data) && $stable(tx_tag));

endmodule

bind ecp_host_regs ecp_host_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_aen    (bus_aen),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pd_out     (pd_out),
    .mode       (cur_mode),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_flush (fifo_flush),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_tag     (tx_tag),
    .tx_data    (tx_data)
);

// File: tb/ecp_host_regs_test.sv
// Bench: scoreboard-style test of the parallel port host register front end.
// Read and transmit expectations are queued by driver tasks.
// Monitors pop and compare them at falling edges.
module ecp_host_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_aen = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pd_in = 8'h3C;
    logic [7:0]  pd_out;
    logic [7:0]  stat_in = 8'h78;
    logic        tx_valid, tx_tag;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    int n_checks = 0;
    int n_errs = 0;
    logic rd_seen = 1'b0;

    logic [7:0] rd_exp_q [$];
    string      rd_req_q [$];
    logic [8:0] tx_exp_q [$];
    string      tx_req_q [$];

    always #10 clk = ~clk;

    ecp_host_regs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_aen   (bus_aen),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pd_in     (pd_in),
        .pd_out    (pd_out),
        .stat_in   (stat_in),
        .tx_valid  (tx_valid),
        .tx_tag    (tx_tag),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [10:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        rd_exp_q.push_back(exp);
        rd_req_q.push_back(req);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic expect_tx(input logic tag, input logic [7:0] d, input string req);
        tx_exp_q.push_back({tag, d});
        tx_req_q.push_back(req);
    endtask

    task automatic set_ready(input logic v);
        @(posedge clk);
        #1 tx_ready = v;
    endtask

    // Read monitor: record accepted reads at the edge, compare half a cycle later
    always @(posedge clk) rd_seen <= bus_rd && !bus_aen;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (rd_exp_q.size() == 0) begin
                n_checks++; n_errs++;
                $display("FAIL read scoreboard: actual %02h expected none", bus_rdata);
            end else begin
                check(rd_req_q.pop_front(), bus_rdata, rd_exp_q.pop_front());
            end
        end
    end

    // Transmitter model: every handshake must match the next expected entry
    always @(negedge clk) begin
        if (tx_valid && tx_ready) begin
            if (tx_exp_q.size() == 0) begin
                n_checks++; n_errs++;
                $display("FAIL R8 unexpected entry: actual %b/%02h expected none", tx_tag, tx_data);
            end else begin
                logic [8:0] e;
                string r;
                e = tx_exp_q.pop_front();
                r = tx_req_q.pop_front();
                check(r, tx_data, e[7:0]);
                check({r, " tag"}, {7'b0, tx_tag}, {7'b0, e[8]});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check("R1 latch", pd_out, 8'h00);
        check("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
        bus_read(11'h402, 8'h01, "R1 xctl after reset");
        bus_read(11'h002, 8'h00, "R1 ctrl after reset");

        // R2: latch drives pins; reads see pins
        bus_write(11'h000, 8'hA5);
        check("R2 latch A5", pd_out, 8'hA5);
        bus_read(11'h000, 8'h3C, "R2 pins read 3C");

        // R4: status and control in mode 000
        bus_read(11'h001, 8'h78, "R4 status");
        bus_write(11'h002, 8'h0F);
        bus_read(11'h002, 8'h0F, "R4 ctrl");

        // R3: vetoed write and read
        @(negedge clk);
        bus_aen = 1'b1; bus_addr = 11'h000; bus_wdata = 8'h11; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 11'h001; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_aen = 1'b0;
        check("R3 latch kept", pd_out, 8'hA5);
        check("R3 rdata kept", bus_rdata, 8'h0F);

        // R5: only the mode field is writable
        bus_write(11'h402, 8'h3F);
        bus_read(11'h402, 8'h21, "R5 xctl layout");

        // R2 in mode 001 with another pin pattern
        pd_in = 8'hC3;
        bus_write(11'h000, 8'h5A);
        check("R2 latch 5A in 001", pd_out, 8'h5A);
        bus_read(11'h000, 8'hC3, "R2 pins read C3");

        // R14 / R10: undefined offsets in mode 001
        bus_write(11'h401, 8'h5A);
        bus_read(11'h401, 8'h00, "R10 cfgb hidden in 001");
        bus_read(11'h400, 8'h00, "R14 400 undefined in 001");
        bus_read(11'h003, 8'h00, "R14 003 undefined");

        // R11: mode 100 refused without enable
        bus_write(11'h402, 8'h80);
        bus_read(11'h402, 8'h21, "R11 epp refused");

        // R10: configuration mode
        bus_write(11'h402, 8'hE0);
        bus_read(11'h402, 8'hE1, "R4 xctl in 111");
        bus_read(11'h401, 8'h00, "R10 cfgb not written in 001");
        bus_read(11'h400, 8'h10, "R10 cfga");
        bus_write(11'h400, 8'h77);
        bus_read(11'h400, 8'h10, "R10 cfga read-only");
        bus_write(11'h401, 8'h01);
        bus_read(11'h401, 8'h01, "R10 cfgb rw");

        // R11: mode 100 accepted with enable
        bus_write(11'h402, 8'h80);
        bus_read(11'h402, 8'h81, "R11 epp accepted");
        bus_read(11'h000, 8'h00, "R14 000 undefined in 100");

        // R6 / R7: ECP mode pushes
        bus_write(11'h402, 8'h60);
        bus_write(11'h000, 8'h12);
        expect_tx(1'b1, 8'h12, "R6 cmd entry");
        bus_write(11'h400, 8'h34);
        expect_tx(1'b0, 8'h34, "R7 data entry");
        bus_write(11'h002, 8'h2F);
        bus_write(11'h000, 8'h56);
        bus_write(11'h002, 8'h0F);
        check("R14 latch untouched in 011", pd_out, 8'h5A);
        bus_read(11'h000, 8'h00, "R14 000 read in 011");
        bus_read(11'h402, 8'h60, "R5 xctl not empty");

        // R13: move to mode 010 keeps entries
        bus_write(11'h402, 8'h40);
        bus_write(11'h400, 8'h9A);
        expect_tx(1'b0, 8'h9A, "R7 data in 010");
        bus_read(11'h402, 8'h40, "R13 no flush 011->010");

        // R8: drain in order
        set_ready(1'b1);
        repeat (10) @(negedge clk);
        set_ready(1'b0);
        check("R6 dir write ignored", 8'(tx_exp_q.size()), 8'h00);
        bus_read(11'h402, 8'h41, "R8 drained");

        // R12: depth 16, seventeenth dropped
        for (int i = 0; i < 17; i++) begin
            bus_write(11'h400, 8'h80 + 8'(i));
            if (i < 16) expect_tx(1'b0, 8'h80 + 8'(i), "R12 entry");
        end
        bus_read(11'h402, 8'h42, "R12 full");
        set_ready(1'b1);
        repeat (24) @(negedge clk);
        set_ready(1'b0);
        check("R12 extra dropped", 8'(tx_exp_q.size()), 8'h00);
        bus_read(11'h402, 8'h41, "R12 empty after drain");

        // R9: test mode readback
        bus_write(11'h402, 8'hC0);
        bus_write(11'h400, 8'h11);
        bus_write(11'h400, 8'h22);
        check("R9 no tx in test", {7'b0, tx_valid}, 8'h00);
        bus_read(11'h400, 8'h11, "R9 first");
        bus_read(11'h400, 8'h22, "R9 second");
        bus_read(11'h400, 8'h00, "R9 empty read");
        bus_read(11'h402, 8'hC1, "R9 empty flag");

        // R13: group move keeps, leaving the group flushes
        bus_write(11'h400, 8'h33);
        bus_write(11'h402, 8'h60);
        bus_read(11'h402, 8'h60, "R13 kept 110->011");
        check("R8 valid in 011", {7'b0, tx_valid}, 8'h01);
        check("R8 head data", tx_data, 8'h33);
        bus_write(11'h402, 8'h20);
        bus_read(11'h402, 8'h21, "R13 flushed 011->001");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule